// File: doc/BRIEF.md
# GPU Command Stream Framer

This block sits at the front of a graphics pipeline and turns a flat stream of 32-bit command words into whole drawing packets. The top byte of each header word is an opcode. It fixes how many parameter words follow, or, for line strips, the rule that ends the packet. The block holds each packet in a local buffer until its final word has arrived. It then replays the packet word by word on a packet output for the rasteriser.

Three opcode families are handled in the framer itself. Single-word environment commands are stored in an eight-entry register file, which is exported whole, and two of its fields are mirrored into a status word. Image-write commands carry a position word and a size word. After them, the block switches into a streaming mode in which each data word supplies two 16-bit pixels to a synchronous pixel-memory write port. The pixels are placed in raster order inside the given rectangle, with wrap-around at the edges of the memory. An environment bit can force the top bit of every written pixel.

Top module: `gpu_cmd_framer`

## Requirements
- R1: While reset is held and on the first cycle after it, in_ready is 1, pkt_valid and pix_we are 0, and status is 0. Environment slot i (bits 32*i+31 down to 32*i of env_regs) holds the opcode 0xE0+i in its top byte and zero below.
- R2: Every opcode outside 0xA0–0xBF and 0xE0–0xE7 leaves as one packet: the header plus the opcode's parameter-word count, with pkt_last on the final word only. Opcodes 0x00–0x1F other than 0x02 carry no parameters, and 0x02 carries 2. Opcodes 0x20–0x3F take 3, 6, 4, 8, 5, 8, 7, 11 parameters for the groups of four opcodes from 0x20 upward.
- R3: No packet word appears before the last word of that packet has been accepted. While the packet is replayed, in_ready is 0.
- R4: A flat line strip (0x48–0x4F) ends at the first word at index 3 or higher (the header is index 0) whose bits under mask 0xF000F000 equal 0x50005000. That ending word belongs to the packet.
- R5: A shaded line strip (0x58–0x5F) tests only the even word indices from 4 upward against the same ending pattern. A matching word at an odd index is plain data.
- R6: A line strip that reaches MAX_WORDS words without an ending word is closed at that word. The next word is parsed as a new header.
- R7: Opcodes 0xE0–0xE7 produce no packet and replace environment slot (opcode & 7) with the whole word. status[10:0] mirrors slot 1 bits 10:0, and status[12:11] mirrors slot 6 bits 1:0.
- R8: An image write (0xA0–0xBF) takes a position word (x = bits 9:0, y = bits 24:16) and then a size word. Its width is ((s-1) & 0x3FF)+1 and its height is (((s>>16)-1) & 0x1FF)+1, so a zero field selects 1024 or 512.
- R9: In streaming mode the pixels are written low half first, then high half. They advance along x for width pixels, then reset x and step y. Addresses are x0+col modulo 1024 and y0+row modulo 512.
- R10: When bit 0 of environment slot 6 is 1, every written pixel has bit 15 set.
- R11: status[27] is 1 from the cycle after the size word is accepted until the final pixel write is presented. It is 0 at all other times, after which the next word is parsed as a header.
- R12: When width×height is odd, the high half of the last data word is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Command word offered |
| in_data | input | 32 | Command or pixel data word |
| in_ready | output | 1 | Word accepted when in_valid is also 1 |
| pkt_valid | output | 1 | Packet word present |
| pkt_data | output | 32 | Packet word |
| pkt_last | output | 1 | Final word of the packet |
| pix_we | output | 1 | Pixel write strobe |
| pix_x | output | 10 | Pixel column |
| pix_y | output | 9 | Pixel row |
| pix_data | output | 16 | Pixel value |
| status | output | 32 | Status word |
| env_regs | output | 256 | Environment register file, slot i at bits 32*i+31:32*i |

## Verification
On every cycle, the bound assertions check the following:
- the packet output stays silent while a packet is being collected;
- replay stalls the input;
- a packet's last word is followed by an idle cycle;
- the forced pixel bit is present while the mask is on;
- consecutive writes on one row step x by one with wrap-around;
- the status mirror changes only after an accepted word;
- the busy bit excludes packet activity.

Exact packet lengths for each opcode group, where line strips end, which odd-index match is ignored, the cap on strip length, rectangle decode with zero fields, and dropping of the odd trailing pixel can only be shown by the bench's scenarios. In those scenarios a scoreboard compares every packet word and every pixel address and value.

// File: rtl/gpu_fr_pkg.sv
package gpu_fr_pkg;

  localparam int WORD_W    = 32;
  localparam int OP_LSB    = 24;
  localparam int ENV_COUNT = 8;
  localparam int ENV_IDX_W = $clog2(ENV_COUNT);
  localparam int PIX_W     = 16;
  localparam int X_BITS    = 10;
  localparam int Y_BITS    = 9;
  localparam int BUSY_BIT  = 27;

  typedef enum logic [1:0] {
    ST_HDR,
    ST_COLLECT,
    ST_EMIT,
    ST_XFER
  } fr_state_e;

  // parameter words following the header (minimum for line strips)
  function automatic logic [3:0] extra_words(input logic [7:0] op);
    case (op[7:5])
      3'd0: return (op == 8'h02) ? 4'd2 : 4'd0;
      3'd1: begin
        case (op[4:2])
          3'd0:    return 4'd3;
          3'd1:    return 4'd6;
          3'd2:    return 4'd4;
          3'd3:    return 4'd8;
          3'd4:    return 4'd5;
          3'd5:    return 4'd8;
          3'd6:    return 4'd7;
          default: return 4'd11;
        endcase
      end
      3'd2: return op[3] ? (op[4] ? 4'd4 : 4'd3) : (op[4] ? 4'd3 : 4'd2);
      3'd3: begin
        case (op[4:2])
          3'd0:    return 4'd2;
          3'd1:    return 4'd3;
          3'd2:    return 4'd1;
          3'd3:    return 4'd0;
          3'd4:    return 4'd1;
          3'd5:    return 4'd2;
          3'd6:    return 4'd1;
          default: return 4'd2;
        endcase
      end
      3'd4:       return 4'd3;
      3'd5, 3'd6: return 4'd2;
      default:    return 4'd0;
    endcase
  endfunction

  function automatic logic is_env_op(input logic [7:0] op);
    return op[7:3] == 5'b11100;
  endfunction

  function automatic logic is_img_op(input logic [7:0] op);
    return op[7:5] == 3'b101;
  endfunction

  function automatic logic is_strip_op(input logic [7:0] op);
    return (op[7:5] == 3'b010) && op[3];
  endfunction

  function automatic logic is_end_marker(input logic [31:0] w);
    return (w & 32'hF000_F000) == 32'h5000_5000;
  endfunction

  // which word slots of a strip may hold the end marker
  function automatic logic end_slot(input int unsigned idx, input logic shaded);
    if (shaded) return (idx >= 4) && (idx[0] == 1'b0);
    return idx >= 3;
  endfunction

  // size field minus one, wrapped to field width (zero selects maximum)
  function automatic logic [X_BITS-1:0] span_x_m1(input logic [X_BITS-1:0] f);
    return f - X_BITS'(1);
  endfunction

  function automatic logic [Y_BITS-1:0] span_y_m1(input logic [Y_BITS-1:0] f);
    return f - Y_BITS'(1);
  endfunction

endpackage

// File: rtl/gpu_fr_envregs.sv
module gpu_fr_envregs
  import gpu_fr_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [WORD_W-1:0]           wr_data,
  input  logic                        img_busy,
  output logic [WORD_W-1:0]           status,
  output logic [ENV_COUNT*WORD_W-1:0] env_flat
);

  localparam logic [7:0] ENV_BASE = 8'hE0;

  for (genvar g = 0; g < ENV_COUNT; g++) begin : g_slot
    logic [WORD_W-1:0] slot_q;
    logic              hit;
    assign hit = wr_en && (wr_data[OP_LSB +: ENV_IDX_W] == ENV_IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= {8'(ENV_BASE + 8'(g)), 24'd0};
      else if (hit) slot_q <= wr_data;
    end
    assign env_flat[g*WORD_W +: WORD_W] = slot_q;
  end

  logic [10:0] draw_mode;
  logic [1:0]  mask_mode;
  assign draw_mode = env_flat[1*WORD_W +: 11];
  assign mask_mode = env_flat[6*WORD_W +: 2];

  always_comb begin
    status           = '0;
    status[10:0]     = draw_mode;
    status[12:11]    = mask_mode;
    status[BUSY_BIT] = img_busy;
  end

endmodule

// File: rtl/gpu_fr_pktbuf.sv
module gpu_fr_pktbuf
  import gpu_fr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
)(
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IW-1:0]     rd_idx,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/gpu_fr_pixstream.sv
module gpu_fr_pixstream
  import gpu_fr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [X_BITS-1:0] pos_x,
  input  logic [Y_BITS-1:0] pos_y,
  input  logic [X_BITS-1:0] size_x,
  input  logic [Y_BITS-1:0] size_y,
  input  logic              word_fire,
  input  logic [WORD_W-1:0] word_data,
  input  logic              mask_force,
  output logic              take_ok,
  output logic              last_evt,
  output logic              pix_we,
  output logic [X_BITS-1:0] pix_x,
  output logic [Y_BITS-1:0] pix_y,
  output logic [PIX_W-1:0]  pix_data
);

  logic [X_BITS-1:0] x0_q, wm1_q, col_q;
  logic [Y_BITS-1:0] y0_q, hm1_q, row_q;
  logic              half_q;
  logic [PIX_W-1:0]  hi_q;

  logic              issue, at_last, row_end;
  logic [PIX_W-1:0]  pix_val;

  assign issue    = word_fire || half_q;
  assign row_end  = (col_q == wm1_q);
  assign at_last  = row_end && (row_q == hm1_q);
  assign last_evt = issue && at_last;
  assign take_ok  = !half_q;
  assign pix_val  = half_q ? hi_q : word_data[PIX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x0_q <= '0; y0_q <= '0; wm1_q <= '0; hm1_q <= '0;
      col_q <= '0; row_q <= '0; half_q <= 1'b0; hi_q <= '0;
    end else if (start) begin
      x0_q   <= pos_x;
      y0_q   <= pos_y;
      wm1_q  <= span_x_m1(size_x);
      hm1_q  <= span_y_m1(size_y);
      col_q  <= '0;
      row_q  <= '0;
      half_q <= 1'b0;
    end else if (issue) begin
      if (word_fire) hi_q <= word_data[WORD_W-1 -: PIX_W];
      half_q <= word_fire && !at_last;
      if (row_end) begin
        col_q <= '0;
        row_q <= row_q + Y_BITS'(1);
      end else begin
        col_q <= col_q + X_BITS'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_we <= 1'b0; pix_x <= '0; pix_y <= '0; pix_data <= '0;
    end else begin
      pix_we <= issue && !start;
      if (issue && !start) begin
        pix_x    <= x0_q + col_q;
        pix_y    <= y0_q + row_q;
        pix_data <= pix_val | {mask_force, {(PIX_W-1){1'b0}}};
      end
    end
  end

endmodule

// File: rtl/gpu_cmd_framer.sv
module gpu_cmd_framer
  import gpu_fr_pkg::*;
#(
  parameter int MAX_WORDS = 16
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [WORD_W-1:0]           in_data,
  output logic                        in_ready,
  output logic                        pkt_valid,
  output logic [WORD_W-1:0]           pkt_data,
  output logic                        pkt_last,
  output logic                        pix_we,
  output logic [X_BITS-1:0]           pix_x,
  output logic [Y_BITS-1:0]           pix_y,
  output logic [PIX_W-1:0]            pix_data,
  output logic [WORD_W-1:0]           status,
  output logic [ENV_COUNT*WORD_W-1:0] env_regs
);

  localparam int IW = $clog2(MAX_WORDS);
  localparam logic [IW-1:0] CAP_IDX = IW'(MAX_WORDS - 1);

  fr_state_e     st_q;
  logic [IW-1:0] widx_q, tgt_q, plast_q, eidx_q;
  logic          strip_q, shaded_q, img_q;

  logic [7:0]        op;
  logic              fire, hdr_fire, col_fire, word_fire;
  logic              env_we, hit_end, hit_cap, hit_len, pkt_done, xfer_start, xfer_end;
  logic              collecting, xfer_active, take_ok;
  logic [3:0]        op_extra;
  logic              buf_we;
  logic [IW-1:0]     buf_widx, buf_ridx;
  logic [WORD_W-1:0] buf_rdata;

  assign op        = in_data[WORD_W-1:OP_LSB];
  assign op_extra  = extra_words(op);
  assign fire      = in_valid && in_ready;
  assign hdr_fire  = fire && (st_q == ST_HDR);
  assign col_fire  = fire && (st_q == ST_COLLECT);
  assign word_fire = fire && (st_q == ST_XFER);

  assign collecting  = (st_q == ST_COLLECT);
  assign xfer_active = (st_q == ST_XFER);

  assign env_we   = hdr_fire && is_env_op(op);
  assign hit_end  = strip_q && end_slot(32'(widx_q), shaded_q) && is_end_marker(in_data);
  assign hit_cap  = strip_q && (widx_q == CAP_IDX);
  assign hit_len  = !strip_q && (widx_q == tgt_q);
  assign pkt_done   = col_fire && (hit_end || hit_cap || hit_len);
  assign xfer_start = pkt_done && img_q;

  always_comb begin
    case (st_q)
      ST_HDR, ST_COLLECT: in_ready = 1'b1;
      ST_XFER:            in_ready = take_ok;
      default:            in_ready = 1'b0;
    endcase
  end

  assign buf_we   = (hdr_fire && !is_env_op(op)) || col_fire;
  assign buf_widx = hdr_fire ? '0 : widx_q;
  assign buf_ridx = (st_q == ST_EMIT) ? eidx_q : IW'(1);

  assign pkt_valid = (st_q == ST_EMIT);
  assign pkt_data  = buf_rdata;
  assign pkt_last  = pkt_valid && (eidx_q == plast_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_HDR;
      widx_q <= '0; tgt_q <= '0; plast_q <= '0; eidx_q <= '0;
      strip_q <= 1'b0; shaded_q <= 1'b0; img_q <= 1'b0;
    end else begin
      case (st_q)
        ST_HDR: if (hdr_fire && !is_env_op(op)) begin
          eidx_q <= '0;
          if (op_extra == 4'd0) begin
            plast_q <= '0;
            st_q    <= ST_EMIT;
          end else begin
            widx_q   <= IW'(1);
            tgt_q    <= IW'(op_extra);
            strip_q  <= is_strip_op(op);
            shaded_q <= op[4];
            img_q    <= is_img_op(op);
            st_q     <= ST_COLLECT;
          end
        end
        ST_COLLECT: if (col_fire) begin
          if (xfer_start) begin
            st_q <= ST_XFER;
          end else if (pkt_done) begin
            plast_q <= widx_q;
            eidx_q  <= '0;
            st_q    <= ST_EMIT;
          end else begin
            widx_q <= widx_q + IW'(1);
          end
        end
        ST_EMIT: begin
          eidx_q <= eidx_q + IW'(1);
          if (eidx_q == plast_q) st_q <= ST_HDR;
        end
        default: if (xfer_end) st_q <= ST_HDR;
      endcase
    end
  end

  gpu_fr_pktbuf #(.DEPTH(MAX_WORDS)) u_buf (
    .clk     (clk),
    .wr_en   (buf_we),
    .wr_idx  (buf_widx),
    .wr_data (in_data),
    .rd_idx  (buf_ridx),
    .rd_data (buf_rdata)
  );

  gpu_fr_envregs u_env (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (env_we),
    .wr_data  (in_data),
    .img_busy (xfer_active),
    .status   (status),
    .env_flat (env_regs)
  );

  gpu_fr_pixstream u_pix (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (xfer_start),
    .pos_x      (buf_rdata[X_BITS-1:0]),
    .pos_y      (buf_rdata[16 +: Y_BITS]),
    .size_x     (in_data[X_BITS-1:0]),
    .size_y     (in_data[16 +: Y_BITS]),
    .word_fire  (word_fire),
    .word_data  (in_data),
    .mask_force (env_regs[6*WORD_W]),
    .take_ok    (take_ok),
    .last_evt   (xfer_end),
    .pix_we     (pix_we),
    .pix_x      (pix_x),
    .pix_y      (pix_y),
    .pix_data   (pix_data)
  );

endmodule

// File: rtl/gpu_fr_checker.sv
module gpu_fr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        pkt_valid,
  input logic        pkt_last,
  input logic        pix_we,
  input logic [9:0]  pix_x,
  input logic [8:0]  pix_y,
  input logic [15:0] pix_data,
  input logic [31:0] status,
  input logic        collecting
);

  // R3: nothing leaves while a packet is still being gathered
  p_quiet_collect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    collecting |-> !pkt_valid);

  // R3: replay stalls the input
  p_emit_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> !in_ready);

  // R2: a last word closes the packet
  p_last_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_last |=> !pkt_valid);

  // R10: forced top pixel bit
  p_mask_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_we && status[11] |-> pix_data[15]);

  // R9: along a row, x steps by one with wrap
  p_raster_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_we && $past(pix_we) && (pix_y == $past(pix_y)) |-> pix_x == $past(pix_x) + 10'd1);

  // R7: mirrored status fields move only after an accepted word
  p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid && in_ready) |-> $stable(status[12:0]));

  // R11: busy excludes packet collection and replay
  p_busy_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    status[27] |-> !pkt_valid && !collecting);

endmodule

bind gpu_cmd_framer gpu_fr_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .pkt_valid  (pkt_valid),
  .pkt_last   (pkt_last),
  .pix_we     (pix_we),
  .pix_x      (pix_x),
  .pix_y      (pix_y),
  .pix_data   (pix_data),
  .status     (status),
  .collecting (collecting)
);

// File: tb/tb_gpu_cmd_framer.sv
`timescale 1ns/1ps
module tb_gpu_cmd_framer;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [31:0]  in_data = '0;
  logic         in_ready, pkt_valid, pkt_last, pix_we;
  logic [31:0]  pkt_data, status;
  logic [9:0]   pix_x;
  logic [8:0]   pix_y;
  logic [15:0]  pix_data;
  logic [255:0] env_regs;

  always #10 clk = ~clk;

  gpu_cmd_framer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_last(pkt_last),
    .pix_we(pix_we), .pix_x(pix_x), .pix_y(pix_y), .pix_data(pix_data),
    .status(status), .env_regs(env_regs)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [32:0] pkt_q[$];
  logic [34:0] pix_q[$];
  logic [31:0] stim[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: compares outputs with the scoreboard between edges
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (pkt_valid) begin
        chk(!in_ready, "R3 stall during replay", 64'(in_ready), 64'd0);
        if (pkt_q.size() == 0) chk(1'b0, "R2 unexpected packet word", 64'(pkt_data), 64'd0);
        else begin
          logic [32:0] e;
          e = pkt_q.pop_front();
          chk({pkt_last, pkt_data} == e, "R2 packet word", 64'({pkt_last, pkt_data}), 64'(e));
        end
      end
      if (pix_we) begin
        if (pix_q.size() == 0) chk(1'b0, "R9 unexpected pixel", 64'({pix_x, pix_y, pix_data}), 64'd0);
        else begin
          logic [34:0] e;
          e = pix_q.pop_front();
          chk({pix_x, pix_y, pix_data} == e, "R9 pixel x/y/data", 64'({pix_x, pix_y, pix_data}), 64'(e));
        end
      end
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      finish_up();
    end
  end

  // driver: called at a falling edge, returns at the falling edge after acceptance
  task automatic send(input logic [31:0] w);
    in_data = w;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic push_pkt(input int from, input int cnt);
    for (int i = 0; i < cnt; i++) pkt_q.push_back({(i == cnt - 1), stim[from + i]});
  endtask

  task automatic send_stim();
    foreach (stim[i]) send(stim[i]);
    stim.delete();
  endtask

  task automatic drain(input string req);
    repeat (20) @(negedge clk);
    chk(pkt_q.size() == 0, req, 64'(pkt_q.size()), 64'd0);
    chk(pix_q.size() == 0, req, 64'(pix_q.size()), 64'd0);
  endtask

  task automatic do_image(input logic [9:0] x0, input logic [8:0] y0, input logic [31:0] sz,
                          input logic m, input logic [15:0] base);
    int w, h, n;
    w = (sz[9:0] == 10'd0) ? 1024 : int'(sz[9:0]);
    h = (sz[24:16] == 9'd0) ? 512 : int'(sz[24:16]);
    n = w * h;
    for (int i = 0; i < n; i++) begin
      logic [9:0]  ex;
      logic [8:0]  ey;
      logic [15:0] ed;
      ex = 10'((int'(x0) + i % w) % 1024);
      ey = 9'((int'(y0) + i / w) % 512);
      ed = (base + 16'(i)) | {m, 15'd0};
      pix_q.push_back({ex, ey, ed});
    end
    send(32'hA000_0000);
    send({7'd0, y0, 6'd0, x0});
    send(sz);
    chk(status[27], "R11 busy after size word", 64'(status[27]), 64'd1);
    for (int k = 0; k < (n + 1) / 2; k++)
      send({base + 16'(2 * k + 1), base + 16'(2 * k)});
    repeat (3) @(negedge clk);
    chk(!status[27], "R11 busy clears after last pixel", 64'(status[27]), 64'd0);
    drain("R8 image drained");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(in_ready, "R1 ready in reset", 64'(in_ready), 64'd1);
    chk(!pkt_valid && !pix_we, "R1 outputs idle in reset", 64'({pkt_valid, pix_we}), 64'd0);
    chk(status == 32'd0, "R1 status reset", 64'(status), 64'd0);
    for (int i = 0; i < 8; i++)
      chk(env_regs[32*i +: 32] == {8'(8'hE0 + i), 24'd0}, "R1 env slot reset",
          64'(env_regs[32*i +: 32]), 64'({8'(8'hE0 + i), 24'd0}));
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && status == 32'd0, "R1 after reset release", 64'({in_ready, status}), 64'h1_0000_0000);

    // R2 single-word and fixed-length packets
    stim = '{32'h0100_0001};                          push_pkt(0, 1); send_stim();
    stim = '{32'h0200_00FF, 32'h0001_0002, 32'h0010_0010}; push_pkt(0, 3); send_stim();
    stim = '{32'h2011_1111, 32'h1, 32'h2, 32'h3};     push_pkt(0, 4); send_stim();
    stim.delete(); stim.push_back(32'h3C00_0000);
    for (int i = 1; i < 12; i++) stim.push_back(32'(i));
    push_pkt(0, 12); send_stim();
    stim.delete(); stim.push_back(32'h2E00_0000);
    for (int i = 1; i < 9; i++) stim.push_back(32'(i * 3));
    push_pkt(0, 9); send_stim();
    drain("R2 packets drained");

    // R3 partial packet holds output
    stim = '{32'h2800_0000, 32'hA, 32'hB, 32'hC, 32'hD};
    push_pkt(0, 5);
    send(stim[0]); send(stim[1]); send(stim[2]);
    for (int i = 0; i < 6; i++) begin
      chk(!pkt_valid, "R3 silent while incomplete", 64'(pkt_valid), 64'd0);
      @(negedge clk);
    end
    send(stim[3]); send(stim[4]); stim.delete();
    drain("R3 packet drained");

    // R4 flat strip: marker at index 1 ignored, index 3 ends
    stim = '{32'h4800_0000, 32'h5000_5000, 32'h0000_0007, 32'h5555_5555};
    push_pkt(0, 4); send_stim();
    stim = '{32'h4C00_0000, 32'h1, 32'h2, 32'h3, 32'h4, 32'h5F00_5F00};
    push_pkt(0, 6); send_stim();
    drain("R4 strips drained");

    // R5 shaded strip: odd index marker is data, index 4 ends
    stim = '{32'h5800_0000, 32'h1, 32'h2, 32'h5000_5000, 32'h5FFF_5FFF};
    push_pkt(0, 5); send_stim();
    drain("R5 strip drained");

    // R6 strip capped at MAX_WORDS, remainder parsed as headers
    stim.delete(); stim.push_back(32'h4A00_0000);
    for (int i = 1; i < 20; i++) stim.push_back(32'h0000_0001);
    push_pkt(0, 16);
    for (int i = 16; i < 20; i++) push_pkt(i, 1);
    send_stim();
    drain("R6 cap drained");

    // R7 environment commands
    send(32'hE100_0ABC);
    chk(status[10:0] == 11'h2BC, "R7 status mirrors slot 1", 64'(status[10:0]), 64'h2BC);
    chk(env_regs[63:32] == 32'hE100_0ABC, "R7 slot 1 stored", 64'(env_regs[63:32]), 64'hE1000ABC);
    send(32'hE600_0003);
    chk(status[12:11] == 2'b11, "R7 status mirrors slot 6", 64'(status[12:11]), 64'd3);
    send(32'hE512_3456);
    chk(env_regs[191:160] == 32'hE512_3456, "R7 slot 5 stored", 64'(env_regs[191:160]), 64'hE5123456);
    drain("R7 no packet from env");

    // R8 R9 R10 wrapped rectangle with forced mask bit
    send(32'hE600_0001);
    do_image(10'd1022, 9'd511, 32'h0002_0004, 1'b1, 16'h0100);
    // R12 odd pixel count, then back to header parsing
    send(32'hE600_0000);
    do_image(10'd5, 9'd7, 32'h0001_0003, 1'b0, 16'h0200);
    stim = '{32'h0100_0055}; push_pkt(0, 1); send_stim();
    drain("R11 header after transfer");
    // R8 zero width field selects 1024, zero height field selects 512
    do_image(10'd0, 9'd3, 32'h0001_0000, 1'b0, 16'h0000);
    do_image(10'd9, 9'd0, 32'h0000_0001, 1'b0, 16'h1000);

    finish_up();
  end

endmodule